// File: doc/BRIEF.md
# Address Space Extension Unit

This block widens the 16-bit addresses that programs generate so they can reach a real memory larger than 64K. A small bank of privileged extension registers holds upper address bits. Each access names its kind, instruction fetch or operand access. The register chosen by that kind is placed above the 16-bit logical address, and the result is the real address. No addition and no table lookup take part, so the logical address passes through untouched.

With the default sizes the bank holds two 3-bit registers, and real addresses are 19 bits wide (512K). Only supervisor-state code may load a register. A load attempted in user state is discarded. It raises a privilege-fault pulse for one cycle, which the surrounding core turns into an exception. After reset every register is zero, so real and logical addresses coincide until the supervisor sets up an address space.

Top module: `addr_xlat`

## Requirements
- R1: While reset is asserted and after reset is released, every extension register reads zero, so `real_addr` equals `{3'b000, log_addr}`, and `priv_fault` is low.
- R2: The low 16 bits of `real_addr` always equal `log_addr` in the same cycle, with no clock delay.
- R3: `acc_kind` = 0 (instruction fetch) selects register 0 and `acc_kind` = 1 (operand access) selects register 1. The selected register's value forms `real_addr[18:16]` in the same cycle.
- R4: When `wr_en` = 1 and `sup_mode` = 1 at a rising clock edge, register `wr_sel` takes `wr_data`. The new value shows in `real_addr` from that edge onward.
- R5: When `wr_en` = 1 and `sup_mode` = 0 at an edge, no register changes.
- R6: `priv_fault` is high for the one cycle after each edge at which `wr_en` = 1 and `sup_mode` = 0. It is low after every other edge, including edges with supervisor writes.
- R7: A supervisor write to one register leaves the other register unchanged.
- R8: With `wr_en` = 0, no register changes and no fault is raised, whatever `sup_mode`, `wr_sel` and `wr_data` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| log_addr | input | 16 | Logical (program) address |
| acc_kind | input | 1 | Access kind: 0 instruction fetch, 1 operand access |
| sup_mode | input | 1 | 1 = supervisor state, 0 = user state |
| wr_en | input | 1 | Request to load an extension register |
| wr_sel | input | 1 | Index of the register to load |
| wr_data | input | 3 | Value to load |
| real_addr | output | 19 | Extended real address |
| priv_fault | output | 1 | One-cycle pulse after a user-state load attempt |

## Verification
A corrupted extension register shows at the ports the next time an access of its kind is presented. The upper three bits of `real_addr` are combinational from the register, so the error appears in the same cycle as that access. A load that is wrongly accepted or wrongly blocked shows in the first access of the affected kind after the edge. A fault pulse that is missing, stretched or spurious shows on `priv_fault` in the single cycle after the attempt. The bench therefore compares both outputs against a reference model in every cycle, not only at selected points.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic {
    ACC_FETCH = 1'b0,
    ACC_OPER  = 1'b1
  } acc_kind_e;

  function automatic logic illegal_load(input logic req, input logic sup);
    return req && !sup;
  endfunction

  function automatic logic legal_load(input logic req, input logic sup);
    return req && sup;
  endfunction

endpackage

// File: rtl/xlat_guard.sv
module xlat_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic sup_mode,
  output logic commit_wr,
  output logic illegal_wr,
  output logic fault_q
);
  import xlat_pkg::*;

  assign commit_wr  = legal_load(wr_en, sup_mode);
  assign illegal_wr = illegal_load(wr_en, sup_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= illegal_wr;
  end
endmodule

// File: rtl/xlat_regbank.sv
module xlat_regbank #(
  parameter int ACC_W  = 1,
  parameter int BANK_W = 3,
  localparam int NUM_REGS = 2 ** ACC_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit_wr,
  input  logic [ACC_W-1:0]             wsel,
  input  logic [BANK_W-1:0]            wdata,
  output logic [NUM_REGS*BANK_W-1:0]   regs_flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [ACC_W-1:0] MY_IDX = ACC_W'(g);
    logic [BANK_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         q <= '0;
      else if (commit_wr && wsel == MY_IDX) q <= wdata;
    end
    assign regs_flat[g*BANK_W +: BANK_W] = q;
  end
endmodule

// File: rtl/xlat_concat.sv
module xlat_concat #(
  parameter int ACC_W  = 1,
  parameter int BANK_W = 3,
  parameter int LOG_W  = 16,
  localparam int NUM_REGS = 2 ** ACC_W,
  localparam int REAL_W   = LOG_W + BANK_W
) (
  input  logic [NUM_REGS*BANK_W-1:0] regs_flat,
  input  logic [ACC_W-1:0]           acc_kind,
  input  logic [LOG_W-1:0]           log_addr,
  output logic [REAL_W-1:0]          real_addr,
  output logic [BANK_W-1:0]          sel_bank
);
  function automatic logic [REAL_W-1:0] join_addr(input logic [BANK_W-1:0] hi,
                                                  input logic [LOG_W-1:0] lo);
    return {hi, lo};
  endfunction

  assign sel_bank  = regs_flat[acc_kind*BANK_W +: BANK_W];
  assign real_addr = join_addr(sel_bank, log_addr);
endmodule

// File: rtl/addr_xlat.sv
module addr_xlat #(
  parameter int ACC_W  = 1,
  parameter int BANK_W = 3,
  parameter int LOG_W  = 16,
  localparam int NUM_REGS = 2 ** ACC_W,
  localparam int REAL_W   = LOG_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  log_addr,
  input  logic [ACC_W-1:0]  acc_kind,
  input  logic              sup_mode,
  input  logic              wr_en,
  input  logic [ACC_W-1:0]  wr_sel,
  input  logic [BANK_W-1:0] wr_data,
  output logic [REAL_W-1:0] real_addr,
  output logic              priv_fault
);
  logic                       commit_wr;
  logic                       illegal_wr;
  logic [NUM_REGS*BANK_W-1:0] xlat_regs_q;
  logic [BANK_W-1:0]          sel_bank;

  xlat_guard u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .sup_mode   (sup_mode),
    .commit_wr  (commit_wr),
    .illegal_wr (illegal_wr),
    .fault_q    (priv_fault)
  );

  xlat_regbank #(.ACC_W(ACC_W), .BANK_W(BANK_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_wr (commit_wr),
    .wsel      (wr_sel),
    .wdata     (wr_data),
    .regs_flat (xlat_regs_q)
  );

  xlat_concat #(.ACC_W(ACC_W), .BANK_W(BANK_W), .LOG_W(LOG_W)) u_concat (
    .regs_flat (xlat_regs_q),
    .acc_kind  (acc_kind),
    .log_addr  (log_addr),
    .real_addr (real_addr),
    .sel_bank  (sel_bank)
  );
endmodule

// File: rtl/addr_xlat_chk.sv
module addr_xlat_chk #(
  parameter int ACC_W  = 1,
  parameter int BANK_W = 3,
  parameter int LOG_W  = 16,
  localparam int NUM_REGS = 2 ** ACC_W,
  localparam int REAL_W   = LOG_W + BANK_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [LOG_W-1:0]           log_addr,
  input logic [ACC_W-1:0]           acc_kind,
  input logic                       sup_mode,
  input logic                       wr_en,
  input logic [ACC_W-1:0]           wr_sel,
  input logic [BANK_W-1:0]          wr_data,
  input logic [REAL_W-1:0]          real_addr,
  input logic                       priv_fault,
  input logic [NUM_REGS*BANK_W-1:0] xlat_regs_q
);
  assert_low_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    real_addr[LOG_W-1:0] == log_addr);

  assert_fetch_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == '0) |-> real_addr[REAL_W-1:LOG_W] == xlat_regs_q[BANK_W-1:0]);

  assert_sup_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sup_mode && wr_sel == '0) |=> xlat_regs_q[BANK_W-1:0] == $past(wr_data));

  assert_user_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sup_mode) |=> $stable(xlat_regs_q));

  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sup_mode) |=> priv_fault);

  assert_no_spurious_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !sup_mode) |=> !priv_fault);

  assert_other_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sup_mode && wr_sel == '0) |=> $stable(xlat_regs_q[2*BANK_W-1:BANK_W]));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(xlat_regs_q));
endmodule

bind addr_xlat addr_xlat_chk #(.ACC_W(ACC_W), .BANK_W(BANK_W), .LOG_W(LOG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .log_addr    (log_addr),
  .acc_kind    (acc_kind),
  .sup_mode    (sup_mode),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .real_addr   (real_addr),
  .priv_fault  (priv_fault),
  .xlat_regs_q (xlat_regs_q)
);

// File: tb/tb_addr_xlat.sv
module tb_addr_xlat;
  localparam int CLK_P = 10;
  localparam int SEED  = 1969;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] log_addr = '0;
  logic        acc_kind = 1'b0;
  logic        sup_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [2:0]  wr_data = '0;
  logic [18:0] real_addr;
  logic        priv_fault;

  int checks = 0;
  int errors = 0;
  logic [2:0] m_reg [2];
  logic       m_fault = 1'b0;

  addr_xlat dut (
    .clk(clk), .rst_n(rst_n), .log_addr(log_addr), .acc_kind(acc_kind),
    .sup_mode(sup_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .real_addr(real_addr), .priv_fault(priv_fault)
  );

  always #(CLK_P/2) clk = ~clk;

  // expected real address: bank bits (times 64K) plus untouched logical address
  function automatic logic [18:0] exp_real(input logic [2:0] bank, input logic [15:0] la);
    return 19'(bank) * 19'd65536 + 19'(la);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check before posedge, update model at posedge
  task automatic step(input logic [15:0] la, input logic ak, input logic sup,
                      input logic we, input logic ws, input logic [2:0] wd,
                      input string tag);
    @(negedge clk);
    log_addr = la; acc_kind = ak; sup_mode = sup;
    wr_en = we; wr_sel = ws; wr_data = wd;
    #1;
    check({tag, " R2 R3 real_addr"}, 32'(real_addr), 32'(exp_real(m_reg[ak], la)));
    check({tag, " R6 priv_fault"}, 32'(priv_fault), 32'(m_fault));
    @(posedge clk);
    if (we && sup) m_reg[ws] = wd;
    m_fault = we && !sup;
  endtask

  initial begin
    m_reg[0] = '0; m_reg[1] = '0;
    log_addr = 16'hFFFF; acc_kind = 1'b1;
    #(CLK_P*2 + 1);
    check("R1 reset real_addr", 32'(real_addr), 32'h0FFFF);
    check("R1 reset priv_fault", 32'(priv_fault), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    step(16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R1 after reset");
    step(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R1 after reset");
    // R4 supervisor load of operand register, R7 fetch register kept
    step(16'h1234, 1'b1, 1'b1, 1'b1, 1'b1, 3'd5, "R4 load");
    step(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R4 readback");
    step(16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R7 other");
    // R5 R6 user attempt on fetch register
    step(16'hABCD, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, "R5 user attempt");
    step(16'hABCD, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R5 R6 after attempt");
    step(16'hABCD, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R6 pulse ends");
    // R6 back-to-back attempts
    step(16'h0001, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, "R6 burst");
    step(16'h0001, 1'b1, 1'b0, 1'b1, 1'b1, 3'd2, "R6 burst");
    step(16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R6 burst");
    step(16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R6 burst end");
    // R8 data on write port without enable
    step(16'h8000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd6, "R8 no enable");
    step(16'h8000, 1'b0, 1'b1, 1'b0, 1'b1, 3'd6, "R8 no enable");
    step(16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R8 check");
    // R4 maximum value into fetch register, then operand
    step(16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0, 3'd7, "R4 max");
    step(16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R4 max readback");
    step(16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, "R7 max other");
    // constrained random traffic
    void'($urandom(SEED));
    for (int i = 0; i < 600; i++) begin
      logic we_r;
      we_r = ($urandom % 3) == 0;
      step(16'($urandom), 1'($urandom), 1'($urandom), we_r, 1'($urandom),
           3'($urandom), "random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule